// File: doc/BRIEF.md
# LIN Slave Node Power-Mode Controller

This block is the digital mode controller of a LIN slave transceiver node. It chooses among five operating modes: unpowered, pre-normal, normal, silent and sleep. From those modes it derives the bus transmitter drive, the regulator enable and its tolerance select, the receive-data output seen by the host controller, and the active-low reset output. The inputs are the host's enable and transmit-data lines, the sampled bus level, a local wake input, and two comparator flags. One flag says the battery supply is valid. The other says the regulator output is in undervoltage.

In normal mode the block sends transmit data onto the bus and returns the bus level on receive data. A falling edge on enable takes the node out of normal mode. The transmit-data level at that edge picks the target: high selects silent mode, low selects sleep mode. A node in silent or sleep mode can be woken in two ways. A remote wake is a dominant pulse on the bus. A local wake is a low pulse on the wake input. Each pulse must last for its filter time before it counts. After a wake the node goes back to pre-normal mode and raises a wake-request flag on receive data. It also reports the wake source through the strength of the pull-down on transmit data.

A dominant time-out stops a stuck-low transmit line from holding the bus dominant. All time constants are parameters counted in system clock cycles. The enable, transmit-data and wake inputs pass through two-flop synchronizers.

Top module: `lin_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, or one cycle after `vs_ok_i` goes low from any mode, the block is unpowered. In that state `reg_en_o`, `res_n_o`, `rxd_o`, `tx_dom_o` and both pull-down outputs are 0.
- R2: When `vs_ok_i` is high in the unpowered state, the block enters pre-normal mode. `reg_en_o`=1 and `reg_tight_o`=1, and `res_n_o` stays low for RST_CYC cycles. Changes on enable inside that reset time have no effect.
- R3: From pre-normal mode (after the reset time) or from silent mode, enable high selects normal mode. Normal mode is the only mode where `tx_dom_o` = NOT transmit data and `rxd_o` = `bus_i`.
- R4: A falling enable edge in normal mode while transmit data is high enters silent mode. In silent mode `reg_en_o`=1, `reg_tight_o`=0, `res_n_o`=1, `rxd_o`=1 and `tx_dom_o`=0.
- R5: A falling enable edge in normal mode while transmit data is low enters sleep mode. In sleep mode `reg_en_o`, `res_n_o`, `rxd_o` and `tx_dom_o` are all 0.
- R6: In silent or sleep mode, a falling edge on `bus_i` followed by at least BUS_WK_CYC consecutive low samples (counting the edge sample) is a remote wake, and the block enters pre-normal mode. A shorter low pulse has no effect.
- R7: In silent or sleep mode, a falling edge on the synchronized `wake_n_i` followed by at least LOC_WK_CYC consecutive low samples is a local wake, and the block enters pre-normal mode. A shorter pulse has no effect.
- R8: After a wake, pre-normal mode drives `rxd_o`=0. It asserts `txd_pd_strong_o` for a local wake or `txd_pd_weak_o` for a remote wake, never both. Both flags clear when enable moves the block to normal mode.
- R9: When the local and the remote filters complete in the same cycle, the wake is reported as local.
- R10: In pre-normal, normal or silent mode, a high `vcc_uv_i` returns the block to pre-normal mode and restarts the RST_CYC reset pulse.
- R11: A wake from sleep mode starts the RST_CYC reset pulse. A wake from silent mode keeps `res_n_o` high.
- R12: `tx_dom_o` is high for at most DOM_TO_CYC consecutive cycles of low synchronized transmit data. It stays low after that until transmit data returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vs_ok_i | input | 1 | Battery supply above its undervoltage threshold |
| vcc_uv_i | input | 1 | Regulator output below its undervoltage threshold |
| en_i | input | 1 | Mode enable from the host |
| txd_i | input | 1 | Transmit data from the host (0 = dominant) |
| bus_i | input | 1 | Sampled bus level (0 = dominant) |
| wake_n_i | input | 1 | Local wake input, active low |
| tx_dom_o | output | 1 | Drive the bus dominant |
| reg_en_o | output | 1 | Regulator enable |
| reg_tight_o | output | 1 | Regulator tight tolerance select |
| rxd_o | output | 1 | Receive data to the host |
| res_n_o | output | 1 | Reset output to the host, active low |
| txd_pd_strong_o | output | 1 | Strong pull-down on transmit data (local wake) |
| txd_pd_weak_o | output | 1 | Weak pull-down on transmit data (remote wake) |

## Verification
The remote and local wake filters can finish in the same cycle. The bench provokes this from silent mode. It pulls the wake input low first, then starts the dominant bus pulse later by the difference of the two filter lengths plus the two-cycle synchronizer delay, so both counters reach their limits on the same edge. The result is judged at the pull-down outputs: only the strong one may be active. The enable edge that picks silent or sleep mode reads transmit data through a synchronizer of the same depth. The bench drives both inputs at the same edge, so the decision rests on the level that was present at the edge.

// File: rtl/lin_pwr_ctrl.sv
module lin_pwr_ctrl #(
  parameter int RST_CYC    = 1250000,
  parameter int BUS_WK_CYC = 11250,
  parameter int LOC_WK_CYC = 16250,
  parameter int DOM_TO_CYC = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_ok_i,
  input  logic vcc_uv_i,
  input  logic en_i,
  input  logic txd_i,
  input  logic bus_i,
  input  logic wake_n_i,
  output logic tx_dom_o,
  output logic reg_en_o,
  output logic reg_tight_o,
  output logic rxd_o,
  output logic res_n_o,
  output logic txd_pd_strong_o,
  output logic txd_pd_weak_o
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam int BW = $clog2(BUS_WK_CYC + 1);
  localparam int LW = $clog2(LOC_WK_CYC + 1);
  localparam int DW = $clog2(DOM_TO_CYC + 1);
  localparam logic [RW-1:0] R_LIM = RW'(RST_CYC);
  localparam logic [BW-1:0] B_LIM = BW'(BUS_WK_CYC);
  localparam logic [LW-1:0] L_LIM = LW'(LOC_WK_CYC);
  localparam logic [DW-1:0] D_LIM = DW'(DOM_TO_CYC);

  typedef enum logic [2:0] {M_OFF, M_PRE, M_NORM, M_SIL, M_SLP} mode_t;
  mode_t mode, mode_n;

  logic [1:0] en_sy, txd_sy, wk_sy;
  logic en_q, wk_q, bus_q;
  logic en_s, txd_s, wk_s;
  assign en_s  = en_sy[1];
  assign txd_s = txd_sy[1];
  assign wk_s  = wk_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sy <= 2'b00; txd_sy <= 2'b11; wk_sy <= 2'b11;
      en_q <= 1'b0; wk_q <= 1'b1; bus_q <= 1'b1;
    end else begin
      en_sy  <= {en_sy[0], en_i};
      txd_sy <= {txd_sy[0], txd_i};
      wk_sy  <= {wk_sy[0], wake_n_i};
      en_q <= en_s; wk_q <= wk_s; bus_q <= bus_i;
    end
  end

  logic listen;
  assign listen = (mode == M_SIL) || (mode == M_SLP);

  logic b_arm, l_arm, b_hit, l_hit;
  logic [BW-1:0] b_cnt;
  logic [LW-1:0] l_cnt;
  assign b_hit = b_arm && (b_cnt >= B_LIM);
  assign l_hit = l_arm && (l_cnt >= L_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_arm <= 1'b0; b_cnt <= '0;
    end else if (!listen || bus_i) begin
      b_arm <= 1'b0; b_cnt <= '0;
    end else if (bus_q) begin
      b_arm <= 1'b1; b_cnt <= BW'(1);
    end else if (b_arm && b_cnt < B_LIM) begin
      b_cnt <= b_cnt + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_arm <= 1'b0; l_cnt <= '0;
    end else if (!listen || wk_s) begin
      l_arm <= 1'b0; l_cnt <= '0;
    end else if (wk_q) begin
      l_arm <= 1'b1; l_cnt <= LW'(1);
    end else if (l_arm && l_cnt < L_LIM) begin
      l_cnt <= l_cnt + LW'(1);
    end
  end

  logic [RW-1:0] r_cnt;
  logic r_done, r_clr, r_set;
  logic fl_loc, fl_rem, fl_clr;
  logic wk_flag, wk_loc;
  assign r_done = (r_cnt == R_LIM);

  always_comb begin
    mode_n = mode;
    r_clr = 1'b0; r_set = 1'b0;
    fl_loc = 1'b0; fl_rem = 1'b0; fl_clr = 1'b0;
    if (!vs_ok_i) begin
      mode_n = M_OFF; fl_clr = 1'b1;
    end else begin
      case (mode)
        M_OFF: begin mode_n = M_PRE; r_clr = 1'b1; end
        M_PRE: begin
          if (vcc_uv_i) r_clr = 1'b1;
          else if (r_done && en_s) begin mode_n = M_NORM; fl_clr = 1'b1; end
        end
        M_NORM: begin
          if (vcc_uv_i) begin mode_n = M_PRE; r_clr = 1'b1; end
          else if (en_q && !en_s) mode_n = txd_s ? M_SIL : M_SLP;
        end
        M_SIL: begin
          if (vcc_uv_i) begin mode_n = M_PRE; r_clr = 1'b1; end
          else if (l_hit) begin mode_n = M_PRE; r_set = 1'b1; fl_loc = 1'b1; end
          else if (b_hit) begin mode_n = M_PRE; r_set = 1'b1; fl_rem = 1'b1; end
          else if (en_s) mode_n = M_NORM;
        end
        M_SLP: begin
          if (l_hit) begin mode_n = M_PRE; r_clr = 1'b1; fl_loc = 1'b1; end
          else if (b_hit) begin mode_n = M_PRE; r_clr = 1'b1; fl_rem = 1'b1; end
        end
        default: mode_n = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_OFF; r_cnt <= '0; wk_flag <= 1'b0; wk_loc <= 1'b0;
    end else begin
      mode <= mode_n;
      if (r_clr) r_cnt <= '0;
      else if (r_set) r_cnt <= R_LIM;
      else if (mode == M_PRE && !r_done) r_cnt <= r_cnt + RW'(1);
      if (fl_loc || fl_rem) begin
        wk_flag <= 1'b1; wk_loc <= fl_loc;
      end else if (fl_clr) begin
        wk_flag <= 1'b0; wk_loc <= 1'b0;
      end
    end
  end

  logic [DW-1:0] d_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_cnt <= '0;
    else if (txd_s) d_cnt <= '0;
    else if (d_cnt < D_LIM) d_cnt <= d_cnt + DW'(1);
  end

  logic is_pre, is_norm, is_sil;
  assign is_pre  = (mode == M_PRE);
  assign is_norm = (mode == M_NORM);
  assign is_sil  = (mode == M_SIL);

  assign tx_dom_o        = is_norm && !txd_s && (d_cnt < D_LIM);
  assign reg_en_o        = is_pre || is_norm || is_sil;
  assign reg_tight_o     = is_pre || is_norm;
  assign res_n_o         = reg_en_o && r_done;
  assign rxd_o           = is_norm ? bus_i : (is_pre ? !wk_flag : is_sil);
  assign txd_pd_strong_o = is_pre && wk_flag && wk_loc;
  assign txd_pd_weak_o   = is_pre && wk_flag && !wk_loc;
endmodule

module lin_pwr_ctrl_chk #(
  parameter int DOM_TO_CYC = 16
) (
  input logic clk,
  input logic rst_n,
  input logic vs_ok_i,
  input logic tx_dom_o,
  input logic reg_en_o,
  input logic reg_tight_o,
  input logic rxd_o,
  input logic res_n_o,
  input logic txd_pd_strong_o,
  input logic txd_pd_weak_o
);
  logic [31:0] dom_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dom_run <= '0;
    else if (!tx_dom_o) dom_run <= '0;
    else if (dom_run <= 32'(DOM_TO_CYC)) dom_run <= dom_run + 32'd1;
  end

  AST_DOM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dom_run <= 32'(DOM_TO_CYC)); // R12
  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_ok_i |=> (!reg_en_o && !res_n_o && !tx_dom_o && !rxd_o)); // R1
  AST_TX_NEEDS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dom_o |-> (reg_tight_o && res_n_o)); // R3
  AST_REG_OFF_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en_o |-> (!res_n_o && !rxd_o && !tx_dom_o)); // R5
  AST_PD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(txd_pd_strong_o && txd_pd_weak_o)); // R8
  AST_PD_FLAG_RXD: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_pd_strong_o || txd_pd_weak_o) |-> (!rxd_o && reg_tight_o && !tx_dom_o)); // R8
endmodule

bind lin_pwr_ctrl lin_pwr_ctrl_chk #(.DOM_TO_CYC(DOM_TO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .vs_ok_i(vs_ok_i), .tx_dom_o(tx_dom_o),
  .reg_en_o(reg_en_o), .reg_tight_o(reg_tight_o), .rxd_o(rxd_o),
  .res_n_o(res_n_o), .txd_pd_strong_o(txd_pd_strong_o),
  .txd_pd_weak_o(txd_pd_weak_o)
);

// File: tb/lin_pwr_ctrl_test.sv
module lin_pwr_ctrl_test;
  localparam int RST = 40;
  localparam int BWK = 12;
  localparam int LWK = 16;
  localparam int DOM = 30;

  logic clk = 1'b0;
  logic rst_n, vs_ok, vcc_uv, en, txd, bus, wake_n;
  logic tx_dom, reg_en, reg_tight, rxd, res_n, pd_s, pd_w;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  lin_pwr_ctrl #(.RST_CYC(RST), .BUS_WK_CYC(BWK), .LOC_WK_CYC(LWK), .DOM_TO_CYC(DOM)) uut (
    .clk(clk), .rst_n(rst_n), .vs_ok_i(vs_ok), .vcc_uv_i(vcc_uv), .en_i(en),
    .txd_i(txd), .bus_i(bus), .wake_n_i(wake_n), .tx_dom_o(tx_dom),
    .reg_en_o(reg_en), .reg_tight_o(reg_tight), .rxd_o(rxd), .res_n_o(res_n),
    .txd_pd_strong_o(pd_s), .txd_pd_weak_o(pd_w)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_dom(input bit txd_sync, input int run);
    return !txd_sync && (run <= DOM);
  endfunction

  task automatic go_normal();
    txd = 1'b1; en = 1'b1; cyc(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; vs_ok = 1'b0; vcc_uv = 1'b0; en = 1'b0;
    txd = 1'b1; bus = 1'b1; wake_n = 1'b1;
    cyc(3);
    chk("R1 reset reg_en", reg_en, 0);
    chk("R1 reset res_n", res_n, 0);
    chk("R1 reset rxd", rxd, 0);
    chk("R1 reset tx_dom", tx_dom, 0);
    rst_n = 1'b1; cyc(2);
    chk("R1 unpowered reg_en", reg_en, 0);

    vs_ok = 1'b1; cyc(5);
    chk("R2 prenormal reg_en", reg_en, 1);
    chk("R2 prenormal tight", reg_tight, 1);
    chk("R2 prenormal res_n low", res_n, 0);
    en = 1'b1; cyc(4); en = 1'b0; txd = 1'b0;
    cyc(RST);
    chk("R2 res_n after reset time", res_n, 1);
    chk("R2 enable ignored during reset", tx_dom, 0);
    chk("R2 prenormal rxd", rxd, 1);
    txd = 1'b1;

    go_normal();
    txd = 1'b0; cyc(3);
    chk("R3 normal tx_dom on low txd", tx_dom, 1);
    txd = 1'b1; cyc(3);
    chk("R3 normal tx_dom on high txd", tx_dom, 0);

    begin
      bit d0 = 1'b1, d1 = 1'b1, lvl = 1'b1;
      int run = 0, rem = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        run = d1 ? 0 : run + 1;
        chk("R12 random tx_dom", tx_dom, exp_dom(d1, run));
        chk("R3 random rxd follows bus", rxd, bus);
        d1 = d0;
        if (rem == 0) begin
          lvl = ~lvl;
          rem = lvl ? $urandom_range(1, 6) : $urandom_range(1, DOM + 8);
        end
        rem--;
        txd = lvl; d0 = lvl;
        bus = 1'($urandom_range(0, 1));
      end
    end
    txd = 1'b1; bus = 1'b1; cyc(4);

    begin
      int hi = 0;
      txd = 1'b0;
      for (int i = 0; i < DOM + 20; i++) begin
        @(negedge clk);
        hi += tx_dom;
      end
      chk("R12 dominant timeout count", hi, DOM);
      chk("R12 held recessive", tx_dom, 0);
      txd = 1'b1; cyc(3); txd = 1'b0; cyc(3);
      chk("R12 released after txd high", tx_dom, 1);
      txd = 1'b1; cyc(3);
    end

    en = 1'b0; cyc(6);
    chk("R4 silent reg_en", reg_en, 1);
    chk("R4 silent tight", reg_tight, 0);
    chk("R4 silent res_n", res_n, 1);
    chk("R4 silent rxd", rxd, 1);
    txd = 1'b0; cyc(4);
    chk("R4 silent no tx", tx_dom, 0);
    txd = 1'b1;

    bus = 1'b0; cyc(BWK - 1); bus = 1'b1; cyc(4);
    chk("R6 short bus pulse ignored", rxd, 1);
    chk("R6 short bus pulse tight", reg_tight, 0);
    bus = 1'b0; cyc(BWK); bus = 1'b1; cyc(4);
    chk("R6 remote wake rxd", rxd, 0);
    chk("R6 remote wake tight", reg_tight, 1);
    chk("R8 remote weak pd", pd_w, 1);
    chk("R8 remote strong pd", pd_s, 0);
    chk("R11 silent wake keeps res_n", res_n, 1);
    en = 1'b1; cyc(6);
    chk("R8 flags clear weak", pd_w, 0);
    chk("R8 flags clear rxd", rxd, 1);
    chk("R3 silent wake to normal tight", reg_tight, 1);

    en = 1'b0; txd = 1'b0; cyc(6);
    chk("R5 sleep reg_en", reg_en, 0);
    chk("R5 sleep res_n", res_n, 0);
    chk("R5 sleep rxd", rxd, 0);
    chk("R5 sleep tx_dom", tx_dom, 0);
    txd = 1'b1;

    wake_n = 1'b0; cyc(LWK - 1); wake_n = 1'b1; cyc(6);
    chk("R7 short wake pulse ignored", reg_en, 0);
    wake_n = 1'b0; cyc(LWK); wake_n = 1'b1; cyc(6);
    chk("R7 local wake reg_en", reg_en, 1);
    chk("R8 local strong pd", pd_s, 1);
    chk("R8 local weak pd", pd_w, 0);
    chk("R8 local rxd flag", rxd, 0);
    chk("R11 sleep wake res_n low", res_n, 0);
    cyc(RST);
    chk("R11 sleep wake res_n high", res_n, 1);
    go_normal();
    chk("R8 strong clears", pd_s, 0);

    en = 1'b0; cyc(6);
    wake_n = 1'b0; cyc(2 + LWK - BWK); bus = 1'b0;
    cyc(BWK + 6);
    chk("R9 coincident strong", pd_s, 1);
    chk("R9 coincident weak", pd_w, 0);
    wake_n = 1'b1; bus = 1'b1;
    go_normal();

    en = 1'b0; cyc(6);
    vcc_uv = 1'b1; cyc(2); vcc_uv = 1'b0; cyc(3);
    chk("R10 uv res_n low", res_n, 0);
    chk("R10 uv tight", reg_tight, 1);
    cyc(RST);
    chk("R10 uv res_n released", res_n, 1);

    go_normal();
    en = 1'b0; txd = 1'b0; cyc(6); txd = 1'b1;
    vs_ok = 1'b0; cyc(3);
    chk("R1 supply loss reg_en", reg_en, 0);
    chk("R1 supply loss res_n", res_n, 0);
    vs_ok = 1'b1; cyc(5);
    chk("R2 repowered tight", reg_tight, 1);
    chk("R2 repowered res_n low", res_n, 0);
    cyc(RST);
    chk("R2 repowered res_n high", res_n, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule